// File: doc/BRIEF.md
# 2D Strided Burst Address Generator

This block turns one transfer request into a stream of bus burst requests that walk a rectangular region of memory. A request carries a start address, a row length, a row count, a row pitch (stride), a cyclic flag and an ID. The row length field holds bytes per row minus one. The row count field holds rows minus one, so a value of zero gives a plain linear transfer. Each row begins one stride after the start of the row before it, and the stride is never smaller than the row length.

Inside a row, bursts are cut at the maximum burst length and at every 4 KB page boundary, so the last burst of a row may be short. Once every row of the pattern has been issued, a one-cycle completion pulse carries the request ID. With the cyclic flag set, the generator starts again from the start address and keeps going until the channel enable drops. The address of the pending burst is visible at all times for status readback. Addresses and lengths are assumed to be multiples of the bus width in bytes. The longest row is 2^LEN_W bytes.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset no burst is presented, no completion pulse is raised, and `req_ready_o` is high while `enable_i` is high.
- R2: `req_ready_o` is high only while the generator is idle and enabled. A request is taken when `req_valid_i` and `req_ready_o` are both high, and the first burst is presented in the next cycle at the request's start address.
- R3: The bursts of one row cover (row length field + 1) / BEAT_BYTES beats at consecutive addresses. `burst_len_o` carries the beat count minus one.
- R4: No burst is longer than MAX_BEATS beats (16 by default).
- R5: No burst crosses a PAGE_BYTES (4096) address boundary.
- R6: Row k (counting from 0) starts at start address + k * stride.
- R7: A pass issues exactly (row count field + 1) rows. A field value of 0 gives a single row.
- R8: While `burst_valid_o` is high and `burst_ready_i` is low, the burst address and length hold steady.
- R9: One cycle after the last burst of a pass is accepted, `done_o` pulses for one cycle with `done_id_o` equal to the request ID.
- R10: With the cyclic flag set, the pattern restarts at the start address after the last row, with no gap and no new request. `done_o` pulses once per pass.
- R11: If `enable_i` is low when a burst is accepted, the generator goes idle and presents nothing more in the next cycle.
- R12: While a burst is presented, `cur_addr_o` equals `burst_addr_o`.
- R13: While `enable_i` is low, no request is taken and no burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable |
| req_valid_i | input | 1 | Transfer request valid |
| req_ready_o | output | 1 | Generator idle and able to take a request |
| req_addr_i | input | ADDR_W | Start address |
| req_xlen_i | input | LEN_W | Bytes per row minus one |
| req_ylen_i | input | LEN_W | Rows minus one |
| req_stride_i | input | LEN_W | Distance in bytes between row starts |
| req_cyclic_i | input | 1 | Repeat the pattern until disabled |
| req_id_i | input | ID_W | Request ID returned with completion |
| burst_valid_o | output | 1 | Burst request valid |
| burst_ready_i | input | 1 | Burst request accepted |
| burst_addr_o | output | ADDR_W | Burst start address |
| burst_len_o | output | log2(MAX_BEATS) | Beats in burst minus one |
| cur_addr_o | output | ADDR_W | Current transfer address |
| done_o | output | 1 | Pass complete pulse |
| done_id_o | output | ID_W | ID of the completed request |

## Verification
The bench builds the block with LEN_W=12, BEAT_BYTES=4, MAX_BEATS=16 and 4 KB pages. With these values the longest possible row, 4096 bytes or 1024 beats, fits in a short run, so the maximum-length case is tested directly. Four-byte beats let random start addresses land a few beats before a page edge, which forces short split bursts. A 12-bit stride keeps multi-row patterns inside a few pages. Cyclic runs rely on the same small geometry: several passes and a disable in the middle of the pattern all finish in a few hundred cycles.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} gen_state_e;
endpackage

// File: rtl/dma2d_burst_calc.sv
module dma2d_burst_calc #(
  parameter int RB_W       = 23,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BEATS  = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int SH        = $clog2(BEAT_BYTES),
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int BC_W      = $clog2(MAX_BEATS) + 1
) (
  input  logic [PG_W-1:0] page_off_i,
  input  logic [RB_W-1:0] rem_i,
  output logic [BC_W-1:0] beats_o,
  output logic            row_end_o
);
  logic [31:0] page_beats, cap;

  // smallest of burst cap, beats to page edge, beats left in row
  always_comb begin
    page_beats = (32'(PAGE_BYTES) - 32'(page_off_i)) >> SH;
    cap        = 32'(MAX_BEATS);
    if (page_beats < cap) cap = page_beats;
    if (32'(rem_i) < cap) cap = 32'(rem_i);
    beats_o    = BC_W'(cap);
    row_end_o  = (32'(rem_i) == cap);
  end
endmodule

// File: rtl/dma2d_row_ctr.sv
module dma2d_row_ctr #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  ylen_i,
  input  logic [LEN_W-1:0]  stride_i,
  input  logic              step_i,
  input  logic              rewind_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] next_start_o,
  output logic              last_row_o
);
  logic [ADDR_W-1:0] base_q, start_q;
  logic [LEN_W-1:0]  stride_q, ylen_q, left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      start_q  <= '0;
      stride_q <= '0;
      ylen_q   <= '0;
      left_q   <= '0;
    end else if (load_i) begin
      base_q   <= base_i;
      start_q  <= base_i;
      stride_q <= stride_i;
      ylen_q   <= ylen_i;
      left_q   <= ylen_i;
    end else if (rewind_i) begin
      start_q  <= base_q;
      left_q   <= ylen_q;
    end else if (step_i) begin
      start_q  <= next_start_o;
      left_q   <= left_q - 1'b1;
    end
  end

  assign base_o       = base_q;
  assign next_start_o = start_q + ADDR_W'(stride_q);
  assign last_row_o   = (left_q == '0);
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BEATS  = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int ID_W       = 5,
  localparam int SH        = $clog2(BEAT_BYTES),
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int BLEN_W    = $clog2(MAX_BEATS),
  localparam int BC_W      = BLEN_W + 1,
  localparam int RB_W      = LEN_W - SH + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_xlen_i,
  input  logic [LEN_W-1:0]  req_ylen_i,
  input  logic [LEN_W-1:0]  req_stride_i,
  input  logic              req_cyclic_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              burst_valid_o,
  input  logic              burst_ready_i,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic [BLEN_W-1:0] burst_len_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              done_o,
  output logic [ID_W-1:0]   done_id_o
);
  gen_state_e        state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [RB_W-1:0]   rem_q, row_beats_q, row_beats_in;
  logic              cyc_q, done_q;
  logic [ID_W-1:0]   id_q, done_id_q;

  logic              accept, hs, row_end, last_row, pass_end, step, rewind;
  logic [BC_W-1:0]   beats;
  logic [ADDR_W-1:0] base_addr, next_start;

  assign req_ready_o   = enable_i && (state_q == ST_IDLE);
  assign accept        = req_valid_i && req_ready_o;
  assign burst_valid_o = (state_q == ST_RUN);
  assign hs            = burst_valid_o && burst_ready_i;
  assign pass_end      = hs && row_end && last_row;
  assign step          = hs && row_end && !last_row;
  assign rewind        = pass_end && cyc_q && enable_i;
  assign row_beats_in  = RB_W'(({1'b0, req_xlen_i} + (LEN_W+1)'(1)) >> SH);

  dma2d_burst_calc #(
    .RB_W(RB_W), .BEAT_BYTES(BEAT_BYTES), .MAX_BEATS(MAX_BEATS), .PAGE_BYTES(PAGE_BYTES)
  ) i_burst_calc (
    .page_off_i (cur_q[PG_W-1:0]),
    .rem_i      (rem_q),
    .beats_o    (beats),
    .row_end_o  (row_end)
  );

  dma2d_row_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_row_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .base_i       (req_addr_i),
    .ylen_i       (req_ylen_i),
    .stride_i     (req_stride_i),
    .step_i       (step),
    .rewind_i     (rewind),
    .base_o       (base_addr),
    .next_start_o (next_start),
    .last_row_o   (last_row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      rem_q       <= '0;
      row_beats_q <= '0;
      cyc_q       <= 1'b0;
      id_q        <= '0;
    end else if (accept) begin
      state_q     <= ST_RUN;
      cur_q       <= req_addr_i;
      rem_q       <= row_beats_in;
      row_beats_q <= row_beats_in;
      cyc_q       <= req_cyclic_i;
      id_q        <= req_id_i;
    end else if (hs) begin
      if (!row_end) begin
        cur_q <= cur_q + (ADDR_W'(beats) << SH);
        rem_q <= rem_q - RB_W'(beats);
      end else if (!last_row) begin
        cur_q <= next_start;
        rem_q <= row_beats_q;
      end else if (cyc_q) begin
        cur_q <= base_addr;
        rem_q <= row_beats_q;
      end else begin
        state_q <= ST_IDLE;
      end
      // disable takes effect once the presented burst is taken
      if (!enable_i) state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      done_id_q <= '0;
    end else begin
      done_q    <= pass_end;
      done_id_q <= id_q;
    end
  end

  assign burst_addr_o = cur_q;
  assign burst_len_o  = BLEN_W'(beats - 1'b1);
  assign cur_addr_o   = cur_q;
  assign done_o       = done_q;
  assign done_id_o    = done_id_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BEATS  = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int SH        = $clog2(BEAT_BYTES),
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int BLEN_W    = $clog2(MAX_BEATS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              req_ready_o,
  input logic              burst_valid_o,
  input logic              burst_ready_i,
  input logic [PG_W-1:0]   page_off_i,
  input logic [BLEN_W-1:0] burst_len_o,
  input logic              done_o
);
  AST_PAGE_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o |-> (32'(page_off_i) + ((32'(burst_len_o) + 1) << SH)) <= 32'(PAGE_BYTES)); // R5

  AST_HOLD_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && !burst_ready_i |=> burst_valid_o && $stable(page_off_i) && $stable(burst_len_o)); // R8

  AST_DONE_AFTER_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(burst_valid_o && burst_ready_i)); // R9

  AST_STOP_ON_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && burst_ready_i && !enable_i |=> !burst_valid_o); // R11

  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !burst_valid_o); // R2

  AST_NO_ACCEPT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && !burst_valid_o |=> !burst_valid_o); // R13
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(
  .BEAT_BYTES(BEAT_BYTES), .MAX_BEATS(MAX_BEATS), .PAGE_BYTES(PAGE_BYTES)
) i_dma2d_addr_gen_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .req_ready_o   (req_ready_o),
  .burst_valid_o (burst_valid_o),
  .burst_ready_i (burst_ready_i),
  .page_off_i    (burst_addr_o[$clog2(PAGE_BYTES)-1:0]),
  .burst_len_o   (burst_len_o),
  .done_o        (done_o)
);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, LEN_W = 12, BB = 4, MAXB = 16, PAGE = 4096, ID_W = 5;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1, req_valid = 1'b0, req_cyclic = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_xlen = '0, req_ylen = '0, req_stride = '0;
  logic [ID_W-1:0]   req_id = '0;
  logic burst_ready = 1'b0;
  logic req_ready, burst_valid, done;
  logic [ADDR_W-1:0] burst_addr, cur_addr;
  logic [3:0] burst_len;
  logic [ID_W-1:0] done_id;

  dma2d_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BB), .MAX_BEATS(MAXB),
                   .PAGE_BYTES(PAGE), .ID_W(ID_W)) i_dma2d_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_addr_i(req_addr), .req_xlen_i(req_xlen),
    .req_ylen_i(req_ylen), .req_stride_i(req_stride), .req_cyclic_i(req_cyclic),
    .req_id_i(req_id), .burst_valid_o(burst_valid), .burst_ready_i(burst_ready),
    .burst_addr_o(burst_addr), .burst_len_o(burst_len), .cur_addr_o(cur_addr),
    .done_o(done), .done_id_o(done_id));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  longint q_addr[$];
  int     q_len[$];
  bit     q_last[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference walk of the 2D pattern
  task automatic gen(longint addr, int xlen, int ylen, int stride, int passes);
    for (int p = 0; p < passes; p++) begin
      longint rs = addr;
      for (int r = 0; r <= ylen; r++) begin
        longint cur = rs;
        int rem = (xlen + 1) / BB;
        while (rem > 0) begin
          int pg = int'((PAGE - (cur % PAGE)) / BB);
          int b = rem;
          if (b > MAXB) b = MAXB;
          if (b > pg) b = pg;
          q_addr.push_back(cur);
          q_len.push_back(b - 1);
          q_last.push_back(r == ylen && rem == b);
          cur += b * BB;
          rem -= b;
        end
        rs += stride;
      end
    end
  endtask

  task automatic run(longint addr, int xlen, int ylen, int stride, bit cyc, int id, int stop_pass);
    bit exp_done = 0, stopping = 0, stop_hs = 0;
    int passes = 0;
    q_addr.delete(); q_len.delete(); q_last.delete();
    gen(addr, xlen, ylen, stride, cyc ? stop_pass + 1 : 1);
    @(negedge clk);
    check(req_ready == 1'b1, "R2", "ready while idle", req_ready, 1);
    req_valid = 1'b1; req_addr = ADDR_W'(addr); req_xlen = LEN_W'(xlen);
    req_ylen = LEN_W'(ylen); req_stride = LEN_W'(stride); req_cyclic = cyc; req_id = ID_W'(id);
    @(negedge clk);
    req_valid = 1'b0;
    check(burst_valid && burst_addr == ADDR_W'(addr), "R2", "first burst address", burst_addr, addr);
    forever begin
      check(done == exp_done, "R9", "done pulse", done, exp_done);
      if (done) begin
        check(done_id == ID_W'(id), "R9", "done id", done_id, id);
        passes++;
      end
      if (stop_hs) begin
        check(burst_valid == 1'b0, "R11", "idle after disable", burst_valid, 0);
        break;
      end
      if (!burst_valid) break;
      check(cur_addr == burst_addr, "R12", "current address", cur_addr, burst_addr);
      if (cyc && passes >= stop_pass && !stopping) begin
        stopping = 1;
        enable = 1'b0;
      end
      burst_ready = ($urandom % 4) != 0;
      exp_done = 0;
      if (burst_ready) begin
        if (q_addr.size() == 0) begin
          check(0, "R7", "extra burst", burst_addr, 0);
          break;
        end
        check(burst_addr == ADDR_W'(q_addr[0]), "R6", "burst address", burst_addr, q_addr[0]);
        check(int'(burst_len) == q_len[0], "R3", "burst length", burst_len, q_len[0]);
        exp_done = q_last[0];
        void'(q_addr.pop_front()); void'(q_len.pop_front()); void'(q_last.pop_front());
        if (stopping) stop_hs = 1;
      end
      @(negedge clk);
    end
    burst_ready = 1'b0;
    if (!cyc) begin
      check(q_addr.size() == 0, "R7", "all rows issued", q_addr.size(), 0);
      check(passes == 1, "R9", "one completion", passes, 1);
    end else begin
      check(passes >= stop_pass, "R10", "cyclic passes", passes, stop_pass);
    end
    enable = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2d01));
    repeat (3) @(negedge clk);
    check(burst_valid == 1'b0 && done == 1'b0, "R1", "reset outputs idle", burst_valid, 0);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(burst_valid == 1'b0, "R1", "no burst after reset", burst_valid, 0);

    // R13: disabled channel takes nothing
    enable = 1'b0; req_valid = 1'b1; req_xlen = 12'd15;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(req_ready == 1'b0 && burst_valid == 1'b0, "R13", "request ignored", burst_valid, 0);
    end
    req_valid = 1'b0; enable = 1'b1;

    run(64'h1000_0FF8, 63, 0, 0, 0, 1, 0);         // R5 page split, R7 one row
    run(64'h2000_0000, 4095, 0, 0, 0, 2, 0);        // R4 max row length
    run(64'h3000_0100, 3, 3, 40, 0, 3, 0);          // R6 single-beat rows
    run(64'h3000_0F00, 99, 2, 100, 0, 4, 0);        // R6 stride equals row
    run(64'h4000_0000, 15, 0, 0, 1, 5, 4);          // R10 one-burst cyclic
    run(64'h4000_0FC0, 79, 2, 200, 1, 6, 2);        // R10 R11 2D cyclic, stop
    for (int i = 0; i < 20; i++) begin
      int xb = 1 + int'($urandom % 70);
      int yl = int'($urandom % 5);
      int st = xb * BB + BB * int'($urandom % 32);
      longint a = 64'h5000_0000 + longint'(($urandom % 65536) & ~32'h3);
      run(a, xb * BB - 1, yl, st, ($urandom % 4) == 0, int'($urandom % 32), 1 + int'($urandom % 2));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule